// File: doc/BRIEF.md
# Barrett Modular Multiplier with Shared Partial-Product Units

This block returns (a·b) mod p for 32-bit residues under a modulus that may change with every operation. Reduction follows Barrett's method. The caller supplies the reciprocal constant mu = floor(2^64 / p) together with each operand pair, so the datapath needs no divider and no particular shape of p. The moduli it serves lie strictly between 2^31 and 2^32, and both operands must already be reduced below p.

Three wide products form a fixed chain: the raw product a·b, the quotient estimate, and the quotient times p. Each product is 33×33 bits. Its own unit builds it from four 17×17 partial products on one multiply-accumulate element with a 48-bit accumulator, so each unit takes four cycles per product and six cycles of latency.

The three units run as a pipeline. A new operation therefore enters every four cycles, and its result leaves a fixed 19 cycles after acceptance.

The input side is valid/ready. `in_ready` rises for one cycle in every four, whatever the caller does, and a transfer happens only in a cycle where `in_valid` and `in_ready` are both high. A caller holding `in_valid` high simply waits for the next ready slot. The output has no back-pressure: `out_valid` pulses once per accepted operation and the result must be taken in that cycle.

Top module: `barrett_mulmod`

## Requirements
- R1: While `rst` is high, `out_valid` and `in_ready` are low. In the first cycle after `rst` falls, `in_ready` is high.
- R2: After reset, `in_ready` is high in exactly one cycle out of every four (pattern 1,0,0,0 repeating), independent of `in_valid`. A caller that holds `in_valid` high waits for the next ready slot, and that operation is taken exactly once.
- R3: Given 2^31 < p < 2^32, a < p, b < p and mu = floor(2^64/p), `out_res` equals (a·b) mod p.
- R4: `out_valid` is high exactly 19 cycles after each accepting cycle and lasts one cycle. It never pulses without a matching acceptance.
- R5: Operations accepted in consecutive ready slots (4 cycles apart) all complete, in acceptance order, each with the correct result.
- R6: Edge operands give the exact residues: a zero operand gives 0, a=1 gives b, a=p-1 with b=1 gives p-1, and a=b=p-1 gives 1.
- R7: Every result is below its own modulus. This holds even when the remainder left by the quotient estimate is as large as 2p or more, in which case two subtractions of p are needed.
- R8: Values on `in_a`, `in_b`, `in_p` and `in_mu` while `in_valid` is low produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Caller offers an operation |
| in_ready | output | 1 | Issue slot open; one cycle in four |
| in_a | input | 32 | First operand, below p |
| in_b | input | 32 | Second operand, below p |
| in_p | input | 32 | Modulus, 2^31 < p < 2^32 |
| in_mu | input | 33 | floor(2^64 / p) |
| out_valid | output | 1 | One-cycle pulse with a result |
| out_res | output | 32 | (a·b) mod p |

## Verification
The bench builds the block at its default residue width of 32 bits. That is the width at which the modulus window (2^31, 2^32) and a 33-bit mu agree, so it reaches moduli at both ends of the window, including 2^32-1 and 2^31+1.

At this width the 17-bit split puts 16 bits in the upper operand half. Products of near-maximal residues therefore drive carries through every accumulate step.

Random moduli and operands over the whole legal range bring in remainders that need zero, one or two corrections. The bursts in consecutive slots overlap all three product units.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;
  localparam int unsigned ACC_W     = 48;
  localparam int unsigned ISSUE_GAP = 4;
  localparam int unsigned MUL_LAT   = 6;

  typedef enum logic [1:0] {
    PH_LL = 2'd0,
    PH_LH = 2'd1,
    PH_HL = 2'd2,
    PH_HH = 2'd3
  } ph_e;
endpackage

// File: rtl/bm_shift_delay.sv
`timescale 1ns/1ps
module bm_shift_delay #(
  parameter int unsigned W = 32,
  parameter int unsigned D = 6
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (D == 0) begin : g_wire
      assign dout = din;
    end else begin : g_sr
      logic [W-1:0] sr [D];
      always_ff @(posedge clk) begin
        sr[0] <= din;
        for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
      end
      assign dout = sr[D-1];
    end
  endgenerate
endmodule

// File: rtl/bm_mac_mul.sv
`timescale 1ns/1ps
module bm_mac_mul #(
  parameter int unsigned OPW = 33,
  parameter int unsigned PW  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OPW-1:0]    x,
  input  logic [OPW-1:0]    y,
  output logic              done,
  output logic [2*OPW-1:0]  prod
);
  import bm_pkg::*;
  localparam int unsigned HIW  = OPW - PW;
  localparam int unsigned ACC  = ACC_W;
  localparam int unsigned TOPW = 2*OPW - 2*PW;

  logic [OPW-1:0] xr, yr;
  logic [3:0]     vs;
  logic           sel_v, mval, aval;
  ph_e            sel_t, mtag, atag;
  logic [PW-1:0]  xl, xh, yl, yh, sel_x, sel_y, ma, mb;
  logic [PW-1:0]  low0, low1;
  logic [2*PW-1:0] pp;
  logic [ACC-1:0] acc, cin, mac_d;

  always_comb begin
    sel_t = PH_LL;
    if (vs[1]) sel_t = PH_LH;
    if (vs[2]) sel_t = PH_HL;
    if (vs[3]) sel_t = PH_HH;
    xl = xr[PW-1:0];
    yl = yr[PW-1:0];
    xh = {{(PW-HIW){1'b0}}, xr[OPW-1:PW]};
    yh = {{(PW-HIW){1'b0}}, yr[OPW-1:PW]};
    sel_x = (sel_t == PH_HL || sel_t == PH_HH) ? xh : xl;
    sel_y = (sel_t == PH_LH || sel_t == PH_HH) ? yh : yl;
  end

  assign sel_v = |vs;

  always_comb begin
    case (mtag)
      PH_LL:   cin = '0;
      PH_HL:   cin = acc;
      default: cin = acc >> PW;
    endcase
  end

  assign pp    = ma * mb;
  assign mac_d = {{(ACC-2*PW){1'b0}}, pp} + cin;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs   <= '0;
      mval <= 1'b0;
      aval <= 1'b0;
    end else begin
      vs   <= {vs[2:0], start};
      mval <= sel_v;
      aval <= mval;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      xr <= x;
      yr <= y;
    end
    if (sel_v) begin
      ma   <= sel_x;
      mb   <= sel_y;
      mtag <= sel_t;
    end
    if (mval) begin
      acc  <= mac_d;
      atag <= mtag;
    end
    if (aval && atag == PH_LL) low0 <= acc[PW-1:0];
    if (aval && atag == PH_HL) low1 <= acc[PW-1:0];
  end

  assign done = aval && (atag == PH_HH);
  assign prod = {acc[TOPW-1:0], low1, low0};
endmodule

// File: rtl/barrett_mulmod.sv
`timescale 1ns/1ps
module barrett_mulmod #(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_p,
  input  logic [W:0]    in_mu,
  output logic          out_valid,
  output logic [W-1:0]  out_res
);
  import bm_pkg::*;
  localparam int unsigned OPW = W + 1;
  localparam int unsigned PW  = W/2 + 1;
  localparam int unsigned PRW = 2*OPW;
  localparam int unsigned RW  = W + 2;
  localparam int unsigned SLW = $clog2(ISSUE_GAP);

  logic [SLW-1:0] slot;
  logic           accept, done1, done2, done3;
  logic [PRW-1:0] prod1, prod2, prod3;
  logic [W:0]     mu_d;
  logic [RW-1:0]  ab_d, r_raw, r1, r2, p_ext;
  logic [W-1:0]   p_mid, p_fin;
  logic           unused_bits;

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + 1'b1;
  end

  assign in_ready = !rst && (slot == '0);
  assign accept   = in_valid && in_ready;

  bm_mac_mul #(.OPW(OPW), .PW(PW)) u_m_ab (
    .clk(clk), .rst(rst), .start(accept),
    .x({1'b0, in_a}), .y({1'b0, in_b}),
    .done(done1), .prod(prod1)
  );

  bm_shift_delay #(.W(OPW), .D(MUL_LAT)) u_d_mu (
    .clk(clk), .din(in_mu), .dout(mu_d)
  );

  bm_mac_mul #(.OPW(OPW), .PW(PW)) u_m_q (
    .clk(clk), .rst(rst), .start(done1),
    .x(prod1[2*W-1:W-1]), .y(mu_d),
    .done(done2), .prod(prod2)
  );

  bm_shift_delay #(.W(RW), .D(2*MUL_LAT)) u_d_ab (
    .clk(clk), .din(prod1[RW-1:0]), .dout(ab_d)
  );

  bm_shift_delay #(.W(W), .D(2*MUL_LAT)) u_d_p1 (
    .clk(clk), .din(in_p), .dout(p_mid)
  );

  bm_mac_mul #(.OPW(OPW), .PW(PW)) u_m_qp (
    .clk(clk), .rst(rst), .start(done2),
    .x(prod2[PRW-1:W+1]), .y({1'b0, p_mid}),
    .done(done3), .prod(prod3)
  );

  bm_shift_delay #(.W(W), .D(MUL_LAT)) u_d_p2 (
    .clk(clk), .din(p_mid), .dout(p_fin)
  );

  assign p_ext = {2'b00, p_fin};
  assign r_raw = ab_d - prod3[RW-1:0];
  assign r1    = (r_raw >= p_ext) ? r_raw - p_ext : r_raw;
  assign r2    = (r1 >= p_ext) ? r1 - p_ext : r1;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= done3;
    if (done3) out_res <= r2[W-1:0];
  end

  assign unused_bits = ^{prod1[PRW-1:2*W], prod2[W:0], prod3[PRW-1:RW]};
endmodule

// File: rtl/bm_chk.sv
`timescale 1ns/1ps
module bm_chk #(
  parameter int unsigned W = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [W-1:0]  out_res,
  input logic [W-1:0]  p_fin,
  input logic [W+1:0]  r_raw,
  input logic          done3
);
  localparam int unsigned LAT = 3*bm_pkg::MUL_LAT + 1;

  // R2: an open slot is followed by a closed one
  a_r2_ready_gap: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R4: one pulse per operation
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4: no result without an acceptance LAT cycles earlier
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, LAT));

  // R4: every acceptance yields a result
  a_r4_no_drop: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready, LAT) |-> out_valid);

  // R7: the estimate leaves less than three moduli
  a_r7_raw_bound: assert property (@(posedge clk) disable iff (rst)
    done3 |-> (r_raw < ({2'b00, p_fin} + {1'b0, p_fin, 1'b0})));

  // R7: output residue below its modulus
  a_r7_below_p: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_res < $past(p_fin)));
endmodule

bind barrett_mulmod bm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_res(out_res), .p_fin(p_fin),
  .r_raw(r_raw), .done3(done3)
);

// File: tb/sim_barrett_mulmod.sv
`timescale 1ns/1ps
module sim_barrett_mulmod;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0, in_p = 32'hFFFF_FFFF;
  logic [32:0] in_mu = '0;
  logic        out_valid;
  logic [31:0] out_res;

  int n_chk = 0, n_fail = 0, cyc = 0, n_acc = 0, n_out = 0;
  logic [31:0] eq[$];
  logic [31:0] pq[$];
  int          cq[$];
  string       rq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  barrett_mulmod u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_p(in_p), .in_mu(in_mu),
    .out_valid(out_valid), .out_res(out_res)
  );

  function automatic logic [31:0] ref_mod(input logic [31:0] a, b, p);
    logic [63:0] pr;
    pr = {32'd0, a} * {32'd0, b};
    return 32'(pr % {32'd0, p});
  endfunction

  function automatic logic [32:0] mu_of(input logic [31:0] p);
    logic [64:0] num, q;
    num = 65'd1 << 64;
    q   = num / {33'd0, p};
    return q[32:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send(input logic [31:0] a, b, p, input string r, output int ac);
    @(negedge clk);
    in_a = a; in_b = b; in_p = p; in_mu = mu_of(p); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    ac = cyc;
    eq.push_back(ref_mod(a, b, p));
    pq.push_back(p);
    cq.push_back(cyc);
    rq.push_back(r);
    n_acc++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rnd_p();
    logic [31:0] p;
    p = $urandom | 32'h8000_0000;
    if (p == 32'h8000_0000) p = 32'h8000_0001;
    return p;
  endfunction

  // output monitor: R3/R4/R7
  logic [31:0] m_e, m_p;
  int          m_c;
  string       m_r;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_out++;
      if (eq.size() == 0) begin
        check(1'b0, "R4 spurious pulse", 1, 0);
      end else begin
        m_e = eq.pop_front(); m_p = pq.pop_front();
        m_c = cq.pop_front(); m_r = rq.pop_front();
        check(out_res == m_e, m_r, out_res, m_e);
        check(out_res < m_p, "R7 below p", out_res, m_p);
        check(cyc - m_c == 19, "R4 latency", cyc - m_c, 19);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int ac, prev, nb;
    logic [31:0] plist [4];
    void'($urandom(32'd7919));
    plist[0] = 32'hFFFF_FFFF; plist[1] = 32'h8000_0001;
    plist[2] = 32'hFFFF_FFFB; plist[3] = 32'h8000_0003;

    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    end
    @(posedge clk);
    #1 rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(in_ready == ((i % 4) == 0), "R1 R2 ready pattern", in_ready, (i % 4) == 0);
    end

    foreach (plist[k]) begin
      send(32'd0, plist[k] - 1, plist[k], "R6 zero a", ac);
      send(plist[k] - 1, 32'd0, plist[k], "R6 zero b", ac);
      send(32'd1, plist[k] - 1, plist[k], "R6 one", ac);
      send(plist[k] - 1, 32'd1, plist[k], "R6 pminus1 by one", ac);
      send(plist[k] - 1, plist[k] - 1, plist[k], "R6 square pminus1", ac);
    end

    send(32'h1234_5678, 32'h7654_3210, 32'hFFFF_FFFF, "R5 burst", prev);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] p;
      p = rnd_p();
      send($urandom % p, $urandom % p, p, "R5 burst", ac);
      check(ac - prev == 4, "R5 slot gap", ac - prev, 4);
      prev = ac;
    end

    repeat (30) @(negedge clk);
    nb = n_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_a = $urandom; in_b = $urandom; in_p = rnd_p(); in_mu = $urandom;
    end
    check(n_out == nb, "R8 idle inputs", n_out, nb);
    check(n_out == n_acc, "R2 R4 count after drain", n_out, n_acc);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] p;
      p = rnd_p();
      send($urandom % p, $urandom % p, p, "R3 random", ac);
      if ((i % 7) == 3) repeat ($urandom % 6) @(negedge clk);
    end

    repeat (40) @(negedge clk);
    check(n_out == n_acc, "R4 final count", n_out, n_acc);
    check(eq.size() == 0, "R4 nothing pending", eq.size(), 0);
    summary();
  end
endmodule